// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits after a clock generator. It receives a fast processor clock and a slower bus clock, where the bus clock is an integer divide of the processor clock with aligned edges. It drives banks of gated and free-running copies of both clocks. Two asynchronous active-low stop requests each control one group. The processor request gates the processor outputs and the memory outputs together. The bus request gates only the bus outputs. Each request passes through a synchronizer in the domain it controls before it is used.

Each group has its own controller, built as a state machine with four named states:

- `ST_RUN`: enabled, with no minimum-on window active.
- `ST_HOLD`: enabled, with the minimum-on window being counted down.
- `ST_STOPPED`: disabled.
- `ST_WAKE`: disabled, and counting out extra restart delay.

The transitions are:

- `ST_RUN` moves to `ST_STOPPED` on a synchronized request.
- `ST_STOPPED` moves to `ST_WAKE` on release. It moves straight to `ST_HOLD` when the wake delay is zero.
- `ST_WAKE` moves to `ST_HOLD` when its counter reaches zero. It returns to `ST_STOPPED` if the request comes back.
- `ST_HOLD` moves to `ST_RUN` at window expiry if no request is present. It moves to `ST_STOPPED` at expiry if a request is still asserted.

The group enable is registered on the falling clock edge and ANDed with the clock. A gated output therefore only loses or gains whole high phases.

Top module: `clk_stop_gate`

## Requirements
- R1: After reset release with both requests high, every gated output follows its clock. Every free-running output follows its clock at all times.
- R2: A gated output is never high while its clock is low. Every high phase it does produce spans the whole high phase of the clock.
- R3: When `cpu_stop_n` falls between two processor rising edges, the next two rising edges still give high phases on `cpu_out` and `sdram_out`. From the third rising edge on, both stay low. All bits of both banks always carry the same value.
- R4: When `cpu_stop_n` rises while the processor group is stopped, the first two following processor rising edges give no pulse. The third gives the first pulse.
- R5: After a processor restart, at least CPU_MIN_ON (default 100) pulses are produced before a stop. A request asserted right after the first pulse and held stops the group directly after pulse CPU_MIN_ON.
- R6: A stop request that is withdrawn before the minimum-on window ends has no effect. The outputs keep pulsing through the window and after it.
- R7: When `pci_stop_n` falls, `pci_out` still pulses on the next two bus rising edges. It is low from the third rising edge on.
- R8: When `pci_stop_n` rises while the bus group is stopped, three bus rising edges pass with no pulse. The first pulse comes on the fourth.
- R9: After a bus restart, at least PCI_MIN_ON (default 10) pulses are produced before a stop. A request held from the first pulse stops the group directly after pulse PCI_MIN_ON.
- R10: The processor request never affects `pci_out`. The bus request never affects `cpu_out` or `sdram_out`. `cpu_free_out`, `sdram_free_out` and `pci_free_out` never stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast processor clock |
| pci_clk | input | 1 | Bus clock, integer divide of `cpu_clk` with aligned edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor and memory groups |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the gated bus group |
| cpu_out | output | N_CPU | Gated processor clocks |
| cpu_free_out | output | 1 | Free-running processor clock |
| sdram_out | output | N_SDRAM | Gated memory clocks |
| sdram_free_out | output | 1 | Free-running memory clock |
| pci_out | output | N_PCI | Gated bus clocks |
| pci_free_out | output | N_PCI_FREE | Free-running bus clocks |

## Verification
A controller left in the wrong state shows up within one clock cycle as a missing or extra high phase, because the enable follows the next state directly.

A hold counter loaded with the wrong value moves the stop edge. That changes the pulse count measured after a restart, which is exact at 100 or 10.

A skipped wake state makes the bus restart come on the third edge instead of the fourth. A lost synchronizer stage makes the stop come one edge early.

An enable that changed while a clock was high would appear as a clipped high phase, or as a level high while the clock is low. A continuous monitor catches that on the same cycle.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;

    // Controller states of one stop channel
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,  // enabled, no minimum-on window pending
        ST_HOLD    = 2'd1,  // enabled, minimum-on window counting
        ST_STOPPED = 2'd2,  // disabled, outputs held low
        ST_WAKE    = 2'd3   // disabled, extra restart delay counting
    } gate_state_t;

    function automatic bit state_enables(gate_state_t s);
        return (s == ST_RUN) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stop_fsm.sv
`timescale 1ns/1ps
module stop_fsm
    import clk_stop_pkg::*;
#(
    parameter int MIN_ON      = 100,
    parameter int WAKE_CYCLES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_sync_n,
    output logic en_req
);

    localparam int HW        = (MIN_ON > 2) ? $clog2(MIN_ON) : 1;
    localparam int HOLD_LOAD = (MIN_ON > 0) ? MIN_ON - 1 : 0;
    localparam int WW        = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
    localparam int WAKE_LOAD = (WAKE_CYCLES > 0) ? WAKE_CYCLES - 1 : 0;

    gate_state_t     state, state_next;
    logic [HW-1:0]   hold_cnt;
    logic [WW-1:0]   wake_cnt;
    logic            stop_req;

    assign stop_req = !stop_sync_n;

    // next-state decision
    always_comb begin
        state_next = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req) state_next = ST_STOPPED;
            end
            ST_HOLD: begin
                if (hold_cnt == '0)
                    state_next = stop_req ? ST_STOPPED : ST_RUN;
            end
            ST_STOPPED: begin
                if (!stop_req)
                    state_next = (WAKE_CYCLES == 0) ? ST_HOLD : ST_WAKE;
            end
            ST_WAKE: begin
                if (stop_req)             state_next = ST_STOPPED;
                else if (wake_cnt == '0)  state_next = ST_HOLD;
            end
            default: state_next = ST_RUN;
        endcase
    end

    // state register and window counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            hold_cnt <= '0;
            wake_cnt <= '0;
        end else begin
            state <= state_next;
            if (state_next == ST_HOLD && state != ST_HOLD)
                hold_cnt <= HW'(HOLD_LOAD);
            else if (state == ST_HOLD && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
            if (state_next == ST_WAKE && state != ST_WAKE)
                wake_cnt <= WW'(WAKE_LOAD);
            else if (state == ST_WAKE && wake_cnt != '0)
                wake_cnt <= wake_cnt - 1'b1;
        end
    end

    // output decode: the enable the gate bank captures on the falling edge
    always_comb begin
        en_req = state_enables(state_next);
    end

    // R5
    hold_blocks_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_cnt != '0) |=> (state == ST_HOLD));

    // R3
    run_stop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req) |=> (state == ST_STOPPED));

    // R4
    release_leaves_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOPPED && !stop_req) |=> (state == ST_WAKE || state == ST_HOLD));

    // R6
    hold_expiry_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_cnt == '0 && !stop_req) |=> (state == ST_RUN));

endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    output logic [WIDTH-1:0] clk_out
);

    logic en_q;

    // enable moves only while the clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_req;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_gate
            assign clk_out[i] = clk & en_q;
        end
    endgenerate

    // R2
    low_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out == '0);

    // R3
    bank_uniform_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (clk_out == '0) || (clk_out == '1));

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
    parameter int N_CPU       = 3,
    parameter int N_SDRAM     = 8,
    parameter int N_PCI       = 5,
    parameter int N_PCI_FREE  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CPU_MIN_ON  = 100,
    parameter int PCI_MIN_ON  = 10,
    parameter int CPU_WAKE    = 0,
    parameter int PCI_WAKE    = 1
) (
    input  logic                  cpu_clk,
    input  logic                  pci_clk,
    input  logic                  rst_n,
    input  logic                  cpu_stop_n,
    input  logic                  pci_stop_n,
    output logic [N_CPU-1:0]      cpu_out,
    output logic                  cpu_free_out,
    output logic [N_SDRAM-1:0]    sdram_out,
    output logic                  sdram_free_out,
    output logic [N_PCI-1:0]      pci_out,
    output logic [N_PCI_FREE-1:0] pci_free_out
);

    localparam int N_FAST = N_CPU + N_SDRAM;

    logic              cpu_sync_n, pci_sync_n;
    logic              cpu_en_req, pci_en_req;
    logic [N_FAST-1:0] fast_gated;

    // processor / memory channel
    stop_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
        .clk(cpu_clk), .rst_n(rst_n), .async_n(cpu_stop_n), .sync_n(cpu_sync_n)
    );
    stop_fsm #(.MIN_ON(CPU_MIN_ON), .WAKE_CYCLES(CPU_WAKE)) u_cpu_fsm (
        .clk(cpu_clk), .rst_n(rst_n), .stop_sync_n(cpu_sync_n), .en_req(cpu_en_req)
    );
    clk_gate_bank #(.WIDTH(N_FAST)) u_cpu_bank (
        .clk(cpu_clk), .rst_n(rst_n), .en_req(cpu_en_req), .clk_out(fast_gated)
    );

    // bus channel
    stop_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
        .clk(pci_clk), .rst_n(rst_n), .async_n(pci_stop_n), .sync_n(pci_sync_n)
    );
    stop_fsm #(.MIN_ON(PCI_MIN_ON), .WAKE_CYCLES(PCI_WAKE)) u_pci_fsm (
        .clk(pci_clk), .rst_n(rst_n), .stop_sync_n(pci_sync_n), .en_req(pci_en_req)
    );
    clk_gate_bank #(.WIDTH(N_PCI)) u_pci_bank (
        .clk(pci_clk), .rst_n(rst_n), .en_req(pci_en_req), .clk_out(pci_out)
    );

    assign cpu_out        = fast_gated[N_CPU-1:0];
    assign sdram_out      = fast_gated[N_FAST-1:N_CPU];
    assign cpu_free_out   = cpu_clk;
    assign sdram_free_out = cpu_clk;

    generate
        for (genvar i = 0; i < N_PCI_FREE; i++) begin : g_pci_free
            assign pci_free_out[i] = pci_clk;
        end
    endgenerate

    // R10
    free_runs_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        cpu_free_out && sdram_free_out);

endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb_top;

    localparam int N_CPU = 3, N_SDRAM = 8, N_PCI = 5, N_PCI_FREE = 3;
    localparam int SYNC = 2, CPU_MIN = 100, PCI_MIN = 10, CPU_WK = 0, PCI_WK = 1;

    logic cpu_clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic [N_CPU-1:0]      cpu_out;
    logic                  cpu_free_out, sdram_free_out;
    logic [N_SDRAM-1:0]    sdram_out;
    logic [N_PCI-1:0]      pci_out;
    logic [N_PCI_FREE-1:0] pci_free_out;

    int checks = 0, errors = 0;
    int glitch_err = 0, free_err = 0, group_err = 0;
    bit mon_on = 1'b0, done = 1'b0;

    always #2.5 cpu_clk = ~cpu_clk;   // 200 MHz
    always #7.5 pci_clk = ~pci_clk;   // divide by three, aligned edges

    clk_stop_gate #(
        .N_CPU(N_CPU), .N_SDRAM(N_SDRAM), .N_PCI(N_PCI), .N_PCI_FREE(N_PCI_FREE),
        .SYNC_STAGES(SYNC), .CPU_MIN_ON(CPU_MIN), .PCI_MIN_ON(PCI_MIN),
        .CPU_WAKE(CPU_WK), .PCI_WAKE(PCI_WK)
    ) dut_i (
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_out(cpu_out), .cpu_free_out(cpu_free_out),
        .sdram_out(sdram_out), .sdram_free_out(sdram_free_out),
        .pci_out(pci_out), .pci_free_out(pci_free_out)
    );

    // expected-value functions derived from the requirements
    function automatic bit exp_after_stop(int k);
        return k <= SYNC;                       // R3 / R7
    endfunction
    function automatic int first_pulse_edge(int wake);
        return SYNC + 1 + wake;                 // R4 / R8
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cpu_step(output logic hi);
        @(posedge cpu_clk); #1.25;
        hi = cpu_out[0];
        if (cpu_out !== {N_CPU{hi}} || sdram_out !== {N_SDRAM{hi}}) group_err++;
    endtask

    task automatic pci_step(output logic hi);
        @(posedge pci_clk); #3.75;
        hi = pci_out[0];
        if (pci_out !== {N_PCI{hi}}) group_err++;
    endtask

    // continuous whole-pulse and free-run monitors (R2, R10)
    always @(posedge cpu_clk) if (mon_on) begin
        logic [N_CPU+N_SDRAM-1:0] a, b;
        #0.2; a = {cpu_out, sdram_out};
        if (!cpu_free_out || !sdram_free_out) free_err++;
        #2.0; b = {cpu_out, sdram_out};
        if (a !== b) glitch_err++;
        #0.5;
        if ({cpu_out, sdram_out} !== '0) glitch_err++;
        if (cpu_free_out || sdram_free_out) free_err++;
    end

    always @(posedge pci_clk) if (mon_on) begin
        logic [N_PCI-1:0] a, b;
        #0.5; a = pci_out;
        if (pci_free_out !== '1) free_err++;
        #6.5; b = pci_out;
        if (a !== b) glitch_err++;
        #1.0;
        if (pci_out !== '0) glitch_err++;
        if (pci_free_out !== '0) free_err++;
    end

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            summary();
            $finish;
        end
    end

    initial begin
        logic h;
        int cnt;
        void'($urandom(32'h00C1_0C57));
        #13.3 rst_n = 1'b1;
        repeat (3) @(posedge cpu_clk);
        mon_on = 1'b1;

        // R1: reset state, both groups running
        for (int i = 0; i < 4; i++) begin cpu_step(h); check("R1 cpu running", h, 1); end
        for (int i = 0; i < 3; i++) begin pci_step(h); check("R1 pci running", h, 1); end

        // R3: processor stop latency
        cpu_step(h);
        cpu_stop_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin cpu_step(h); check("R3 stop edge", h, exp_after_stop(k)); end
        // R10: bus group unaffected while processor group stopped
        for (int i = 0; i < 3; i++) begin pci_step(h); check("R10 pci during cpu stop", h, 1); end

        // R4: processor restart latency
        cpu_step(h);
        cpu_stop_n = 1'b1;
        for (int k = 1; k <= first_pulse_edge(CPU_WK); k++) begin
            cpu_step(h); check("R4 restart edge", h, k == first_pulse_edge(CPU_WK));
        end
        // R5: held request stops right after the minimum window
        cpu_stop_n = 1'b0;
        cnt = 1;
        for (int i = 0; i < 300; i++) begin cpu_step(h); if (h) cnt++; else break; end
        check("R5 cpu pulses before stop", cnt, CPU_MIN);
        for (int i = 0; i < 3; i++) begin cpu_step(h); check("R5 stays stopped", h, 0); end

        // R6: request withdrawn inside the window is ignored
        cpu_stop_n = 1'b1;
        for (int k = 1; k <= first_pulse_edge(CPU_WK); k++) cpu_step(h);
        check("R6 restarted", h, 1);
        cpu_stop_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin cpu_step(h); if (h) cnt++; end
        cpu_stop_n = 1'b1;
        for (int i = 0; i < 200; i++) begin cpu_step(h); if (h) cnt++; end
        check("R6 pulses kept", cnt, 220);

        // R7: bus stop latency
        pci_step(h);
        pci_stop_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin pci_step(h); check("R7 stop edge", h, exp_after_stop(k)); end
        for (int i = 0; i < 4; i++) begin cpu_step(h); check("R10 cpu during pci stop", h, 1); end

        // R8: bus restart latency
        pci_step(h);
        pci_stop_n = 1'b1;
        for (int k = 1; k <= first_pulse_edge(PCI_WK); k++) begin
            pci_step(h); check("R8 restart edge", h, k == first_pulse_edge(PCI_WK));
        end
        // R9: bus minimum window
        pci_stop_n = 1'b0;
        cnt = 1;
        for (int i = 0; i < 60; i++) begin pci_step(h); if (h) cnt++; else break; end
        check("R9 pci pulses before stop", cnt, PCI_MIN);
        pci_stop_n = 1'b1;
        for (int i = 0; i < 6; i++) pci_step(h);
        check("R8 bus back", h, 1);

        // random request waveforms at arbitrary times
        for (int i = 0; i < 40; i++) begin
            #($urandom_range(1, 7000) / 10.0);
            if ($urandom_range(0, 1) == 1) cpu_stop_n = ~cpu_stop_n;
            else                           pci_stop_n = ~pci_stop_n;
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (300) cpu_step(h);
        check("R4 cpu recovered", h, 1);
        pci_step(h);
        check("R8 pci recovered", h, 1);

        // both stopped together, then check all gated outputs idle
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        repeat (150) cpu_step(h);
        check("R3 cpu parked", h, 0);
        pci_step(h);
        check("R7 pci parked", h, 0);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (20) cpu_step(h);

        mon_on = 1'b0;
        #20;
        check("R2 whole pulses, low when clock low", glitch_err, 0);
        check("R10 free outputs never stop", free_err, 0);
        check("R3 bank bits agree", group_err, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule